// File: doc/BRIEF.md
# Match-Capture Timer/Counter

This block is a timer peripheral built around a free-running counter of parameterised width, 32 bits by default and 16 bits as an alternative. In timer mode the counter advances once for every full pass of a programmable prescaler. In counter mode it advances on chosen edges of an external count input, and the prescaler is not used. Software drives the block through a small register port. It starts and stops the counter, holds it at zero, sets the prescaler limit, and programs the match and capture behaviour.

Four match channels compare the count with their own programmed values. A channel can set a status flag, return the counter to zero, or stop it, in any combination. It can also act on its own output pin by driving it low, driving it high, toggling it, or leaving it alone. A separate capture input copies the counter into a capture register on the selected edge. Status flags are cleared by writing ones to them, and a single interrupt line reports the flags that have been enabled.

Register map (4-bit address): 0 control {bit1 hold, bit0 run}; 1 mode {bit5 capture interrupt enable, bits 4:3 capture edge, bits 2:1 count edge, bit0 counter mode}; 2 prescale limit; 3 count (read-only); 4 capture (read-only); 5 flags {bit4 capture, bits 3:0 match}; 6 match configuration, 5 bits per channel i at bits 5i+4..5i; 7 prescale count (read-only); 8 to 11 match values 0 to 3. Edge codes are 00 none, 01 rising, 10 falling and 11 both.

Top module: `evt_timer`

## Requirements
- R1: During and after a synchronous reset, the count, the prescale count, the capture value, the flags, the pins, `irq` and `reg_rdata` are all zero, and the counter is stopped.
- R2: In timer mode, with run=1 and hold=0, the prescale count climbs by one per clock. Once it is greater than or equal to the limit, the next clock returns it to 0 and advances the count by one, so the count advances every limit+1 clocks. With run=0 the count and the prescale count keep their values.
- R3: While the hold bit (control bit 1) is 1, the count and the prescale count are loaded with zero on every clock and no match event occurs.
- R4: In counter mode (mode bit0=1), the count advances once for each edge of `cnt_in` selected by mode bits 2:1, measured after a 2-flop synchronizer and edge detector (three clocks from pin to count). Code 00 never counts, and the prescale count stays unchanged.
- R5: When a count step produces the value of match register i, flag bit i is set on that same clock. Writing 1 to a flag bit clears it, and when a set and a clear arrive together the set wins.
- R6: If the reset bit (bit 5i+1) of channel i is set and the count equals match i, the next count step loads 0 instead of count+1.
- R7: If the stop bit (bit 5i+2) of channel i is set, a match event on channel i clears the run bit on the same clock, and the count then stays at the match value.
- R8: On a match event of channel i, bits 5i+4..5i+3 act on `match_pin[i]`: 00 leaves it unchanged, 01 drives it low, 10 drives it high, 11 toggles it.
- R9: An edge of `cap_in` selected by mode bits 4:3, measured after a 2-flop synchronizer, copies the current count into the capture register and sets flag bit 4.
- R10: `irq` goes high one clock after any flag is set whose enable is also set. The enables are bit 5i for match i and mode bit 5 for capture. `irq` goes low one clock after the last such flag is cleared.
- R11: `reg_rdata` presents the register selected by `reg_addr` one clock after the address is applied, zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register address |
| reg_wdata | input | BW (32) | Register write data |
| reg_rdata | output | BW (32) | Registered read data |
| cnt_in | input | 1 | External count input (counter mode) |
| cap_in | input | 1 | Capture trigger input |
| match_pin | output | NM (4) | Match-driven output pins |
| irq | output | 1 | Interrupt request |

## Verification
The counter is run against several prescale limits, and the bench watches the prescale count directly. This separates an off-by-one in the wrap compare from a count that never moves. In counter mode the count input is toggled under each of the four edge codes, which shows whether rising and falling detection have been swapped and whether code 00 is really inert. Overlapping match channels are set up so that one channel resets the count while the others toggle, set or clear their pins, and a separate channel stops the counter. A long stretch of random register writes and input toggling then mixes flag clears with new events, catching set-versus-clear priority and interrupt enable errors that directed patterns miss.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_act_e;

  // per-channel configuration, 5 bits: {act[1:0], stop, clr, irq}
  typedef struct packed {
    pin_act_e act;
    logic     stop;
    logic     clr;
    logic     irq;
  } mcfg_t;

  localparam int A_CTRL   = 0;
  localparam int A_MODE   = 1;
  localparam int A_PSC    = 2;
  localparam int A_COUNT  = 3;
  localparam int A_CAP    = 4;
  localparam int A_FLAGS  = 5;
  localparam int A_MCFG   = 6;
  localparam int A_PCNT   = 7;
  localparam int A_MATCH0 = 8;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync (
  input  logic       clk,
  input  logic       rst,
  input  logic       d,
  input  logic [1:0] sel,
  output logic       ev
);
  // sh[1:0] synchronizer, sh[2] previous synchronized value
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], d};
  end

  assign ev = (sel[0] & sh[1] & ~sh[2]) | (sel[1] & ~sh[1] & sh[2]);
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         hold,
  input  logic         ext_mode,
  input  logic         ext_ev,
  input  logic [W-1:0] lim,
  output logic [W-1:0] pcnt,
  output logic         tick
);
  logic active;
  logic wrap;

  assign active = run & ~hold;
  assign wrap   = pcnt >= lim;
  assign tick   = active & (ext_mode ? ext_ev : wrap);

  always_ff @(posedge clk) begin
    if (rst || hold)            pcnt <= '0;
    else if (active && !ext_mode) pcnt <= wrap ? '0 : pcnt + W'(1);
  end
endmodule

// File: rtl/evt_match_chan.sv
module evt_match_chan
  import evt_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cnt_next,
  input  logic [W-1:0] mval,
  input  mcfg_t        cfg,
  output logic         zero_req,
  output logic         hit,
  output logic         pin
);
  assign zero_req = cfg.clr & (count == mval);
  assign hit      = tick & (cnt_next == mval);

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else if (hit) begin
      case (cfg.act)
        PIN_LOW:  pin <= 1'b0;
        PIN_HIGH: pin <= 1'b1;
        PIN_FLIP: pin <= ~pin;
        default:  pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int W  = 32,
  parameter int BW = 32,
  parameter int NM = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  input  logic          cnt_in,
  input  logic          cap_in,
  output logic [NM-1:0] match_pin,
  output logic          irq
);
  localparam int FW  = NM + 1;
  localparam int CW  = $bits(mcfg_t);
  localparam int MCW = CW * NM;

  logic          run_q, hold_q, ext_mode_q, cap_ie_q;
  logic [1:0]    cnt_sel_q, cap_sel_q;
  logic [W-1:0]  psc_lim_q, psc_cnt, count_q, cap_q, cnt_next;
  logic [FW-1:0] flags_q, flag_set, flag_clr, flag_ie;
  mcfg_t         mcfg_q [NM];
  logic [W-1:0]  mval_q [NM];
  logic [MCW-1:0] mcfg_flat;
  logic [NM-1:0] hit, zero_req, stop_mask, match_ie;
  logic          tick, zero_any, cnt_ev, cap_ev;
  logic          wr_ctrl, wr_mode, wr_psc, wr_flags, wr_mcfg;
  logic [BW-1:0] rd_mux;

  assign wr_ctrl  = reg_we && (reg_addr == AW'(A_CTRL));
  assign wr_mode  = reg_we && (reg_addr == AW'(A_MODE));
  assign wr_psc   = reg_we && (reg_addr == AW'(A_PSC));
  assign wr_flags = reg_we && (reg_addr == AW'(A_FLAGS));
  assign wr_mcfg  = reg_we && (reg_addr == AW'(A_MCFG));

  evt_edge_sync u_cnt_sync (
    .clk(clk), .rst(rst), .d(cnt_in), .sel(cnt_sel_q), .ev(cnt_ev)
  );
  evt_edge_sync u_cap_sync (
    .clk(clk), .rst(rst), .d(cap_in), .sel(cap_sel_q), .ev(cap_ev)
  );

  evt_prescaler #(.W(W)) u_psc (
    .clk(clk), .rst(rst), .run(run_q), .hold(hold_q), .ext_mode(ext_mode_q),
    .ext_ev(cnt_ev), .lim(psc_lim_q), .pcnt(psc_cnt), .tick(tick)
  );

  assign zero_any = |zero_req;
  assign cnt_next = zero_any ? '0 : count_q + W'(1);

  for (genvar i = 0; i < NM; i++) begin : g_match
    evt_match_chan #(.W(W)) u_chan (
      .clk(clk), .rst(rst), .tick(tick), .count(count_q), .cnt_next(cnt_next),
      .mval(mval_q[i]), .cfg(mcfg_q[i]), .zero_req(zero_req[i]), .hit(hit[i]),
      .pin(match_pin[i])
    );
    assign stop_mask[i]            = mcfg_q[i].stop;
    assign match_ie[i]             = mcfg_q[i].irq;
    assign mcfg_flat[CW*i +: CW]   = mcfg_q[i];
  end

  // match configuration and values
  always_ff @(posedge clk) begin
    for (int i = 0; i < NM; i++) begin
      if (rst) begin
        mcfg_q[i] <= '0;
        mval_q[i] <= '0;
      end else begin
        if (wr_mcfg) mcfg_q[i] <= mcfg_t'(reg_wdata[CW*i +: CW]);
        if (reg_we && (reg_addr == AW'(A_MATCH0 + i))) mval_q[i] <= reg_wdata[W-1:0];
      end
    end
  end

  // control, mode, prescale limit
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      hold_q     <= 1'b0;
      ext_mode_q <= 1'b0;
      cnt_sel_q  <= 2'b00;
      cap_sel_q  <= 2'b00;
      cap_ie_q   <= 1'b0;
      psc_lim_q  <= '0;
    end else begin
      if (wr_ctrl) {hold_q, run_q} <= reg_wdata[1:0];
      if (|(hit & stop_mask)) run_q <= 1'b0;
      if (wr_mode) {cap_ie_q, cap_sel_q, cnt_sel_q, ext_mode_q} <= reg_wdata[5:0];
      if (wr_psc) psc_lim_q <= reg_wdata[W-1:0];
    end
  end

  // counter and capture
  always_ff @(posedge clk) begin
    if (rst || hold_q) count_q <= '0;
    else if (tick)     count_q <= cnt_next;
  end

  always_ff @(posedge clk) begin
    if (rst)         cap_q <= '0;
    else if (cap_ev) cap_q <= count_q;
  end

  // flags and interrupt
  assign flag_set = {cap_ev, hit};
  assign flag_clr = wr_flags ? reg_wdata[FW-1:0] : '0;
  assign flag_ie  = {cap_ie_q, match_ie};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      irq     <= |(flags_q & flag_ie);
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      AW'(A_CTRL):  rd_mux = BW'({hold_q, run_q});
      AW'(A_MODE):  rd_mux = BW'({cap_ie_q, cap_sel_q, cnt_sel_q, ext_mode_q});
      AW'(A_PSC):   rd_mux = BW'(psc_lim_q);
      AW'(A_COUNT): rd_mux = BW'(count_q);
      AW'(A_CAP):   rd_mux = BW'(cap_q);
      AW'(A_FLAGS): rd_mux = BW'(flags_q);
      AW'(A_MCFG):  rd_mux = BW'(mcfg_flat);
      AW'(A_PCNT):  rd_mux = BW'(psc_cnt);
      default:      rd_mux = '0;
    endcase
    for (int i = 0; i < NM; i++)
      if (reg_addr == AW'(A_MATCH0 + i)) rd_mux = BW'(mval_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int W  = 32,
  parameter int NM = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          hold,
  input logic          run,
  input logic [W-1:0]  count,
  input logic          zero_any,
  input logic [NM-1:0] hit,
  input logic [NM-1:0] stop_mask,
  input logic [NM-1:0] flags,
  input logic          cap_ev,
  input logic [W-1:0]  cap_val
);
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold |=> count == '0); // R3
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!tick && !hold) |=> $stable(count)); // R2
  AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (tick && !hold && !zero_any) |=> count == $past(count) + W'(1)); // R2
  AST_ZERO_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (tick && !hold && zero_any) |=> count == '0); // R6
  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (|(hit & stop_mask)) |=> !run); // R7
  AST_HIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> (flags & $past(hit)) == $past(hit)); // R5
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
    cap_ev |=> cap_val == $past(count)); // R9
endmodule

bind evt_timer evt_timer_chk #(.W(W), .NM(NM)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .hold(hold_q), .run(run_q),
  .count(count_q), .zero_any(zero_any), .hit(hit), .stop_mask(stop_mask),
  .flags(flags_q[NM-1:0]), .cap_ev(cap_ev), .cap_val(cap_q)
);

// File: tb/test_evt_timer.sv
module test_evt_timer;
  localparam int W  = 32;
  localparam int BW = 32;
  localparam int NM = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] wdata = '0;
  logic          cnt_in = 1'b0;
  logic          cap_in = 1'b0;
  wire  [BW-1:0] rdata;
  wire  [NM-1:0] pins;
  wire           irq;

  int    vectors = 0;
  int    miscmp  = 0;
  bit    started = 0;
  bit    done    = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  evt_timer #(.W(W), .BW(BW), .NM(NM), .AW(AW)) i_evt_timer (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .cnt_in(cnt_in), .cap_in(cap_in), .match_pin(pins), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit             m_run, m_hold, m_ext, m_kie;
  bit [1:0]       m_csel, m_ksel;
  bit [W-1:0]     m_lim, m_psc, m_cnt, m_cap;
  bit [NM:0]      m_flags;
  bit [5*NM-1:0]  m_mcfg;
  bit [W-1:0]     m_mval [NM];
  bit [NM-1:0]    m_pins;
  bit             m_irq;
  bit [BW-1:0]    m_rd;
  bit [2:0]       cs, ks;

  function automatic bit [BW-1:0] mread(bit [AW-1:0] a);
    int ai = int'(a);
    case (ai)
      0: return BW'({m_hold, m_run});
      1: return BW'({m_kie, m_ksel, m_csel, m_ext});
      2: return BW'(m_lim);
      3: return BW'(m_cnt);
      4: return BW'(m_cap);
      5: return BW'(m_flags);
      6: return BW'(m_mcfg);
      7: return BW'(m_psc);
      default: if (ai >= 8 && ai < 8 + NM) return BW'(m_mval[ai-8]);
               else return '0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit cev, kev, act, tk, zr;
    bit [NM-1:0] hitv, iev, stv;
    bit [W-1:0] nx;
    started = 1;
    if (rst) begin
      m_run = 0; m_hold = 0; m_ext = 0; m_kie = 0; m_csel = 0; m_ksel = 0;
      m_lim = 0; m_psc = 0; m_cnt = 0; m_cap = 0; m_flags = 0; m_mcfg = 0;
      for (int i = 0; i < NM; i++) m_mval[i] = 0;
      m_pins = 0; m_irq = 0; m_rd = 0; cs = 0; ks = 0;
    end else begin
      for (int i = 0; i < NM; i++) begin
        iev[i] = m_mcfg[5*i];
        stv[i] = m_mcfg[5*i+2];
      end
      m_rd  = mread(addr);
      m_irq = |(m_flags & {m_kie, iev});
      cev = (m_csel[0] && cs[1] && !cs[2]) || (m_csel[1] && !cs[1] && cs[2]);
      kev = (m_ksel[0] && ks[1] && !ks[2]) || (m_ksel[1] && !ks[1] && ks[2]);
      act = m_run && !m_hold;
      tk  = act && (m_ext ? cev : (m_psc >= m_lim));
      zr  = 0;
      for (int i = 0; i < NM; i++)
        if (m_mcfg[5*i+1] && m_cnt == m_mval[i]) zr = 1;
      nx = zr ? '0 : m_cnt + 1;
      for (int i = 0; i < NM; i++) hitv[i] = tk && (nx == m_mval[i]);
      // pins
      for (int i = 0; i < NM; i++)
        if (hitv[i])
          case (m_mcfg[5*i+3 +: 2])
            2'b01: m_pins[i] = 0;
            2'b10: m_pins[i] = 1;
            2'b11: m_pins[i] = ~m_pins[i];
            default: ;
          endcase
      m_flags = (m_flags & ~((we && addr == 5) ? wdata[NM:0] : '0)) | {kev, hitv};
      if (kev) m_cap = m_cnt;
      if (m_hold) m_cnt = 0;
      else if (tk) m_cnt = nx;
      if (m_hold) m_psc = 0;
      else if (act && !m_ext) m_psc = (m_psc >= m_lim) ? '0 : m_psc + 1;
      if (we && addr == 0) {m_hold, m_run} = wdata[1:0];
      if (|(hitv & stv)) m_run = 0;
      if (we && addr == 1) {m_kie, m_ksel, m_csel, m_ext} = wdata[5:0];
      if (we && addr == 2) m_lim = wdata[W-1:0];
      if (we && addr == 6) m_mcfg = wdata[5*NM-1:0];
      for (int i = 0; i < NM; i++)
        if (we && int'(addr) == 8 + i) m_mval[i] = wdata[W-1:0];
      cs = {cs[1:0], cnt_in};
      ks = {ks[1:0], cap_in};
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(cur_req, "reg_rdata", rdata, m_rd);
      chk(cur_req, "match_pin", BW'(pins), BW'(m_pins));
      chk(cur_req, "irq", BW'(irq), BW'(m_irq));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, logic [BW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic watch(int a, int n);
    addr = AW'(a);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip_cnt(int n);
    for (int k = 0; k < n; k++) begin
      cnt_in = ~cnt_in;
      watch(3, 4);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    watch(3, 2);
    chk("R1", "count after reset", rdata, '0);
    chk("R1", "pins after reset", BW'(pins), '0);
    chk("R1", "irq after reset", BW'(irq), '0);
    watch(5, 3);
    watch(7, 2);

    // R2: timer mode with prescale limit 2, then 0
    cur_req = "R2";
    for (int i = 0; i < NM; i++) wr(8 + i, 32'hFFFF_FF00);
    wr(2, 2);
    wr(0, 1);
    watch(3, 20);
    watch(7, 10);
    wr(2, 0);
    watch(3, 10);
    wr(0, 0);
    watch(3, 5);

    // R11: read every address
    cur_req = "R11";
    for (int a = 0; a < 12; a++) watch(a, 2);

    // R3: hold clears and blocks counting
    cur_req = "R3";
    wr(0, 1);
    watch(3, 6);
    wr(0, 3);
    watch(3, 6);
    watch(7, 3);
    wr(0, 1);
    watch(3, 4);

    // R5 and R10: match flag, interrupt, clear
    cur_req = "R5";
    wr(0, 2);
    wr(2, 0);
    wr(8, 5);
    wr(6, 32'h1);
    wr(0, 1);
    watch(5, 10);
    cur_req = "R10";
    wr(5, 32'h1);
    watch(5, 4);

    // R6: reset on match 1 at 7
    cur_req = "R6";
    wr(0, 2);
    wr(9, 7);
    wr(6, (32'b00010 << 5) | 32'h1);
    wr(0, 1);
    watch(3, 25);

    // R8: pin actions, channel 3 resets at 8
    cur_req = "R8";
    wr(0, 2);
    wr(8, 3); wr(9, 4); wr(10, 6); wr(11, 8);
    wr(6, (32'b11010 << 15) | (32'b01000 << 10) | (32'b10000 << 5) | 32'b11000);
    wr(0, 1);
    watch(3, 40);

    // R7: stop on match 2 at 10
    cur_req = "R7";
    wr(0, 2);
    wr(10, 10);
    wr(6, 32'b00100 << 10);
    wr(0, 1);
    watch(3, 16);
    watch(0, 3);

    // R4: counter mode with each edge code
    cur_req = "R4";
    wr(0, 2);
    wr(2, 5);
    wr(1, 32'b0011);
    wr(0, 1);
    flip_cnt(6);
    wr(1, 32'b0101);
    flip_cnt(6);
    wr(1, 32'b0111);
    flip_cnt(6);
    wr(1, 32'b0001);
    flip_cnt(4);
    watch(7, 2);

    // R9: capture on rising, falling, both with interrupt
    cur_req = "R9";
    wr(1, 32'b101000);
    wr(2, 0);
    wr(0, 1);
    watch(3, 5);
    cap_in = 1'b1; watch(4, 6);
    cap_in = 1'b0; watch(4, 6);
    watch(5, 2);
    wr(5, 32'h10);
    wr(1, 32'b110000);
    cap_in = 1'b1; watch(4, 6);
    cap_in = 1'b0; watch(4, 6);
    wr(1, 32'b111000);
    cap_in = 1'b1; watch(4, 6);
    cap_in = 1'b0; watch(4, 6);
    wr(5, 32'h1F);
    watch(5, 3);

    // random mix: writes, clears, toggles
    cur_req = "R5";
    wr(0, 2);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) begin
        int a;
        a = $urandom_range(0, 11);
        we = 1'b1; addr = AW'(a);
        case (a)
          0: wdata = ($urandom_range(0, 7) == 0) ? 32'd3 : 32'd1;
          1: wdata = BW'($urandom_range(0, 63));
          2: wdata = BW'($urandom_range(0, 3));
          5: wdata = BW'($urandom_range(0, 31));
          6: wdata = BW'($urandom);
          default: wdata = BW'($urandom_range(0, 24));
        endcase
      end else begin
        we = 1'b0;
        addr = AW'($urandom_range(0, 11));
      end
      if ($urandom_range(0, 3) == 0) cnt_in = ~cnt_in;
      if ($urandom_range(0, 7) == 0) cap_in = ~cap_in;
    end
    @(negedge clk);
    we = 1'b0;
    watch(5, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscmp++;
      $display("FAIL %s watchdog expired actual=hung expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule